// File: doc/BRIEF.md
# Single-Bit Time-Slot Master for an Open-Drain One-Wire Bus

This block is the bit layer of a one-wire bus master. Each request asks it to run one time slot on the shared open-drain line: a write-one slot, a write-zero slot, or a read slot. Every slot opens with the master pulling the line low. Only the length of that low pulse tells a write-one slot from a write-zero slot. A read slot uses the short pulse, releases the line, and takes a sample at a fixed point inside the slot. A responding device pulls the line low through that point to return a 0. It leaves the line alone to return a 1. Once the slot time is over, the line stays released for a recovery gap before the next slot may begin.

Every duration is a parameter counted in system clock cycles. The defaults assume a 1 µs tick: write-one low 6, write-zero low 60, read low 6, sample at 15, slot 70, recovery 5. The line input is passed through a synchronizer before it is used. The pulldown output is active low: a 0 enables the external pulldown. Higher layers build bytes and commands out of these slots.

The controller has four states. IDLE waits for a request. PULL drives the line low. FREE keeps the line released until the slot length is reached, and takes the read sample there. RECOVER keeps the line released for the recovery gap. The transitions are as follows. The ACCEPT transition goes from IDLE to PULL on a valid request with a non-reserved code. END_PULL goes from PULL to FREE when the low time for the slot type has elapsed. END_SLOT goes from FREE to RECOVER when the slot length is reached. END_REC goes from RECOVER to IDLE when the recovery gap has elapsed, and it raises `done`.

Top module: `ow_slot_master`

## Requirements
- R1: After reset `pull_n` is 1, `busy` is 0, `done` is 0 and `rd_bit` is 0, and `pull_n` is 1 whenever `busy` is 0.
- R2: A request with `req_kind` = 2'd0 (write one) drives `pull_n` low for exactly T_W1_LOW consecutive cycles, starting in the cycle after the request is sampled.
- R3: A request with `req_kind` = 2'd1 (write zero) drives `pull_n` low for exactly T_W0_LOW consecutive cycles.
- R4: A request with `req_kind` = 2'd2 (read) drives `pull_n` low for exactly T_RD_LOW consecutive cycles. `busy` rises in the same cycle that `pull_n` falls.
- R5: `busy` stays high for exactly T_SLOT + T_REC cycles per slot. `pull_n` stays high for the whole recovery part of that time.
- R6: A read slot sets `rd_bit` to 0 when the line is held low through the sample point, and to 1 when the line is released. Write slots leave `rd_bit` unchanged.
- R7: `done` is a single-cycle pulse in the first cycle after `busy` falls, and it follows every slot type.
- R8: A request made while `busy` is 1 is ignored: it does not lengthen the slot, does not pull the line low again, and does not start a second slot.
- R9: The code `req_kind` = 2'd3 is reserved. A request carrying it starts no slot.
- R10: A request made in the same cycle as the `done` pulse is accepted at once, so `pull_n` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Slot request, sampled while idle |
| req_kind | input | 2 | 0 write one, 1 write zero, 2 read, 3 reserved |
| line_in | input | 1 | Raw line level, synchronized inside the block |
| pull_n | output | 1 | Active-low pulldown enable for the line |
| busy | output | 1 | High from slot start until recovery ends |
| done | output | 1 | One-cycle pulse when a slot and its recovery finish |
| rd_bit | output | 1 | Bit sampled by the latest read slot |

## Verification
The bench builds the block with short durations: write-one low 2, write-zero low 8, read low 2, sample at 5, slot 10, recovery 3. With these values a full slot and its recovery take 13 cycles, so every slot type, each read value, and requests landing mid-slot or exactly on the `done` cycle can all be exercised within a few hundred cycles. The sample point sits three cycles after the read pulse ends. This tests that a released line, seen through the two-flop synchronizer, reads as 1, while a responding device that holds the line low returns 0.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

    typedef enum logic [1:0] {
        K_WR1 = 2'd0,
        K_WR0 = 2'd1,
        K_RD  = 2'd2,
        K_RSV = 2'd3
    } slot_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULL    = 2'd1,
        ST_FREE    = 2'd2,
        ST_RECOVER = 2'd3
    } slot_state_t;

endpackage

// File: rtl/ow_bit_sync.sv
module ow_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[gi] <= 1'b1;
                end else if (gi == 0) begin
                    chain_q[gi] <= d_in;
                end else begin
                    chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
    parameter int CNT_W   = 8,
    parameter int CNT_MAX = 70
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the slot timer never runs past the longest interval it measures
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(CNT_MAX));

endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
    import ow_slot_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int T_W1_LOW = 6,
    parameter int T_W0_LOW = 60,
    parameter int T_RD_LOW = 6,
    parameter int T_SAMPLE = 15,
    parameter int T_SLOT   = 70,
    parameter int T_REC    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             line_s,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             pull_n,
    output logic             busy,
    output logic             done,
    output logic             rd_bit
);

    localparam logic [CNT_W-1:0] W1_LAST   = CNT_W'(T_W1_LOW - 1);
    localparam logic [CNT_W-1:0] W0_LAST   = CNT_W'(T_W0_LOW - 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(T_RD_LOW - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(T_SLOT - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(T_REC - 1);
    localparam logic [CNT_W-1:0] SMP_AT    = CNT_W'(T_SAMPLE);

    slot_state_t state_q, state_d;
    slot_kind_t  kind_q;
    logic [CNT_W-1:0] pull_last;
    logic accept;

    assign accept = req_valid && (slot_kind_t'(req_kind) != K_RSV);

    always_comb begin
        unique case (kind_q)
            K_WR0:   pull_last = W0_LAST;
            K_RD:    pull_last = RD_LAST;
            default: pull_last = W1_LAST;
        endcase
    end

    // next-state and timer clear
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (accept) state_d = ST_PULL;
            end
            ST_PULL: begin
                if (cnt == pull_last) state_d = ST_FREE;
            end
            ST_FREE: begin
                if (cnt == SLOT_LAST) begin
                    state_d = ST_RECOVER;
                    cnt_clr = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt == REC_LAST) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_WR1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && accept) kind_q <= slot_kind_t'(req_kind);
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_n <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b0;
            rd_bit <= 1'b0;
        end else begin
            pull_n <= (state_d != ST_PULL);
            busy   <= (state_d != ST_IDLE);
            done   <= (state_q == ST_RECOVER) && (state_d == ST_IDLE);
            if (state_q == ST_FREE && kind_q == K_RD && cnt == SMP_AT)
                rd_bit <= line_s;
        end
    end

    // R1: the line is never pulled while idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> pull_n);

    // R4: a pulldown only starts together with a new busy period
    a_r4_pull_opens_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_n) |-> $rose(busy));

    // R5: the line stays released during recovery
    a_r5_recover_released: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RECOVER |-> (pull_n && busy));

    // R6: rd_bit only moves after a read-slot sample
    a_r6_rd_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bit) |-> $past(kind_q == K_RD && state_q == ST_FREE));

    // R7: done is a single pulse just after busy falls
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a request during a slot does not change the slot type
    a_r8_busy_holds_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_IDLE && req_valid) |=> $stable(kind_q));

endmodule

// File: rtl/ow_slot_master.sv
module ow_slot_master #(
    parameter int T_W1_LOW    = 6,
    parameter int T_W0_LOW    = 60,
    parameter int T_RD_LOW    = 6,
    parameter int T_SAMPLE    = 15,
    parameter int T_SLOT      = 70,
    parameter int T_REC       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       line_in,
    output logic       pull_n,
    output logic       busy,
    output logic       done,
    output logic       rd_bit
);

    localparam int CNT_MAX = (T_SLOT > T_REC) ? T_SLOT : T_REC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             line_s;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;

    ow_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_in),
        .d_out (line_s)
    );

    ow_slot_timer #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    ow_slot_fsm #(
        .CNT_W    (CNT_W),
        .T_W1_LOW (T_W1_LOW),
        .T_W0_LOW (T_W0_LOW),
        .T_RD_LOW (T_RD_LOW),
        .T_SAMPLE (T_SAMPLE),
        .T_SLOT   (T_SLOT),
        .T_REC    (T_REC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .line_s    (line_s),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .pull_n    (pull_n),
        .busy      (busy),
        .done      (done),
        .rd_bit    (rd_bit)
    );

endmodule

// File: tb/ow_slot_master_tb.sv
module ow_slot_master_tb_top;

    localparam int P_W1  = 2;
    localparam int P_W0  = 8;
    localparam int P_RD  = 2;
    localparam int P_SMP = 5;
    localparam int P_SLT = 10;
    localparam int P_REC = 3;
    localparam int BUSY_LEN = P_SLT + P_REC;

    localparam int NV = 8;
    // vector table: slot code, responder holds line low, expected low cycles
    localparam int V_KIND [NV] = '{0, 1, 2, 1, 2, 0, 2, 2};
    localparam int V_ZERO [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};
    localparam int V_LOW  [NV] = '{P_W1, P_W0, P_RD, P_W0, P_RD, P_W1, P_RD, P_RD};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic slave_zero = 1'b0;
    logic line_in;
    logic pull_n, busy, done, rd_bit;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic exp_bit = 1'b0;

    always #2 clk = ~clk;

    assign line_in = pull_n & ~(slave_zero & busy);

    ow_slot_master #(
        .T_W1_LOW (P_W1), .T_W0_LOW (P_W0), .T_RD_LOW (P_RD),
        .T_SAMPLE (P_SMP), .T_SLOT (P_SLT), .T_REC (P_REC),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
        .line_in (line_in), .pull_n (pull_n), .busy (busy), .done (done),
        .rd_bit (rd_bit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    // Issue one request, then measure the slot; returns at the done cycle.
    // inject >= 0 fires a write-zero request that many cycles into the slot.
    task automatic run_slot(input int kind, input int inject,
                            output int lows, output int busys, output int dn);
        int falls;
        logic prev;
        req_kind  = 2'(kind);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lows = 0; busys = 0; falls = 0; prev = 1'b1;
        for (int i = 0; i < 200 && busy; i++) begin
            if (i == inject) begin req_kind = 2'd1; req_valid = 1'b1; end
            else req_valid = 1'b0;
            busys++;
            if (!pull_n) lows++;
            if (prev && !pull_n) falls++;
            prev = pull_n;
            @(negedge clk);
        end
        req_valid = 1'b0;
        dn = int'(done);
        if (falls > 1) lows = -falls;
    endtask

    initial begin
        int lows, busys, dn;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pull_n reset", int'(pull_n), 1);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        check("R1 rd_bit reset", int'(rd_bit), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            slave_zero = V_ZERO[v][0];
            run_slot(V_KIND[v], -1, lows, busys, dn);
            if (V_KIND[v] == 2) exp_bit = ~V_ZERO[v][0];
            check(V_KIND[v] == 0 ? "R2 write-one low" :
                  V_KIND[v] == 1 ? "R3 write-zero low" : "R4 read low", lows, V_LOW[v]);
            check("R5 busy length", busys, BUSY_LEN);
            check("R7 done pulse", dn, 1);
            check("R6 rd_bit", int'(rd_bit), int'(exp_bit));
            @(negedge clk);
            check("R7 done single", int'(done), 0);
            slave_zero = 1'b0;
            @(negedge clk);
        end

        // R9: reserved code starts nothing
        req_kind = 2'd3; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 reserved busy", int'(busy), 0);
        check("R9 reserved pull_n", int'(pull_n), 1);
        repeat (3) @(negedge clk);
        check("R9 reserved done", int'(done), 0);

        // R8: request mid-slot ignored
        run_slot(0, 4, lows, busys, dn);
        check("R8 low unchanged", lows, P_W1);
        check("R8 busy unchanged", busys, BUSY_LEN);
        @(negedge clk);
        check("R8 no second slot", int'(busy), 0);
        repeat (2) @(negedge clk);

        // R8: request during recovery ignored
        run_slot(1, P_SLT + 1, lows, busys, dn);
        check("R8 recovery req low", lows, P_W0);
        check("R8 recovery req busy", busys, BUSY_LEN);
        @(negedge clk);
        check("R8 recovery no slot", int'(busy), 0);
        repeat (2) @(negedge clk);

        // R10: request in the done cycle accepted at once
        slave_zero = 1'b1;
        run_slot(0, -1, lows, busys, dn);
        check("R10 done seen", dn, 1);
        req_kind = 2'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 busy at once", int'(busy), 1);
        check("R10 pull_n at once", int'(pull_n), 0);
        while (busy) @(negedge clk);
        check("R10 read returns 0", int'(rd_bit), 0);
        slave_zero = 1'b0;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule